// File: doc/BRIEF.md
# Spare-Core Calibration Rotation Controller

This controller keeps a set of interleaved converter cores calibrated in the background without ever pausing the data stream. Each group has three cores. Two of them feed the two output slots, and the third sits offline while an external calibration engine works on it. The controller asks the engine for a calibration with a one-cycle start pulse and names the core. It waits for the engine's done pulse. It then moves the freshly calibrated core into one of the output slots, and the core it displaces becomes the next offline core. This repeats for as long as the mode stays enabled.

The swap is split into two staggered steps to limit glitches. The slot's data-source select moves to the new core a programmable number of cycles after the done pulse. The output-mux select moves after a second programmable delay counted from the same pulse. Both delays are 5-bit values, and 31 and 30 cycles are the recommended settings. The parameter `NUM_GROUPS` sets the number of groups, and each group rotates on its own. Indices are local to a group. For group 0, local indices 0, 1 and 2 are physical cores 0, 1 and 2. For group 1, local indices 0, 1 and 2 are physical cores 4, 5 and 3.

Top module: `spare_cal_rotator`

## Requirements
- R1: In the cycle after reset, each group has slot 0 on core 0, slot 1 on core 1 (both source and mux selects), core 2 offline, no calibration busy and no start pulse.
- R2: A group starts a calibration only when `bg_cal_en`=1, `hw_trig_en`=0 and `sw_trig`=1. A start is a one-cycle `cal_start` pulse with `cal_core` equal to the offline core. Under any other input combination no start occurs.
- R3: `cal_busy` is high from the start pulse until `cal_done` is sampled. No start is issued while a group is busy. A `cal_done` that arrives while the group is not busy has no effect.
- R4: After a done pulse is sampled at clock edge E0, the replaced slot's source select shows the new core from edge E(src+1) onward, where src is the source delay.
- R5: The replaced slot's mux select shows the new core from edge E(mux+1) onward, counted from the same edge E0. It changes before the source select whenever mux < src.
- R6: The replaced slot alternates, starting with slot 0 after reset. The displaced core becomes the offline core. From reset the sequence of (slot0, slot1, offline) is (0,1,2) → (2,1,0) → (2,0,1) → (1,0,2) → (1,2,0).
- R7: `slot_core` and `spare_core` change together at edge E(max(src,mux)+1) and always hold three distinct indices.
- R8: At that completion edge, if the enable condition still holds, the next calibration starts on the new offline core in the same cycle.
- R9: If the enable condition drops during a calibration, `cal_busy` stays high until done. After done, no swap happens, all selects stay as they are, and no new start is issued until the condition returns.
- R10: Both delays are captured when done is sampled. Changes to `src_dly` or `mux_dly` during a swap do not affect that swap.
- R11: Groups are independent. A done pulse to one group changes nothing in another group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bg_cal_en | input | 1 | Background calibration mode enable |
| hw_trig_en | input | 1 | Hardware trigger enable (must be 0 to rotate) |
| sw_trig | input | 1 | Software trigger (must be 1 to rotate) |
| src_dly | input | 5 | Cycles from done to source switch |
| mux_dly | input | 5 | Cycles from done to mux switch |
| cal_done | input | NUM_GROUPS | Per-group calibration complete pulse |
| cal_start | output | NUM_GROUPS | Per-group calibration start pulse |
| cal_core | output | 2*NUM_GROUPS | Per-group core to calibrate |
| cal_busy | output | NUM_GROUPS | Per-group calibration in progress |
| src_sel | output | 4*NUM_GROUPS | Per group: slot 0 source in bits [1:0], slot 1 source in bits [3:2] |
| mux_sel | output | 4*NUM_GROUPS | Per group: slot 0 mux select in bits [1:0], slot 1 mux select in bits [3:2] |
| slot_core | output | 4*NUM_GROUPS | Per group: committed core of slot 0 in bits [1:0], slot 1 in bits [3:2] |
| spare_core | output | 2*NUM_GROUPS | Per group: committed offline core |

## Verification
A wrong assignment register shows up as duplicated or out-of-order indices on `slot_core`/`spare_core`, and `cal_core` names the wrong core on the very next start pulse. A miscounting delay timer moves `src_sel` or `mux_sel` one or more cycles away from E(d+1), so the bench samples every cycle of each swap window. A state machine that ignores the enable, or acts on a stray done, produces a start pulse or select change within one or two cycles, and the bench watches for it over idle windows.

// File: rtl/scr_pkg.sv
package scr_pkg;
    localparam int IDX_W = 2;
    localparam int DLY_W = 5;
    localparam int SLOTS = 2;

    typedef logic [IDX_W-1:0] core_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAL,
        ST_SWAP
    } rot_st_e;

    typedef struct packed {
        core_t off;
        core_t s1;
        core_t s0;
    } asg_t;

    function automatic logic all_distinct(asg_t a);
        return (a.s0 != a.s1) && (a.s0 != a.off) && (a.s1 != a.off);
    endfunction

    function automatic logic [DLY_W-1:0] dmax(logic [DLY_W-1:0] a, logic [DLY_W-1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/scr_swap_timer.sv
module scr_swap_timer
    import scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             kick,
    input  logic [DLY_W-1:0] src_dly,
    input  logic [DLY_W-1:0] mux_dly,
    output logic             src_fire,
    output logic             mux_fire,
    output logic             last,
    output logic             active
);
    logic [DLY_W-1:0] cnt, src_q, mux_q, end_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            src_q  <= '0;
            mux_q  <= '0;
            end_q  <= '0;
        end else if (kick) begin
            active <= 1'b1;
            cnt    <= '0;
            src_q  <= src_dly;
            mux_q  <= mux_dly;
            end_q  <= dmax(src_dly, mux_dly);
        end else if (active) begin
            if (cnt == end_q) active <= 1'b0;
            else              cnt    <= cnt + 1'b1;
        end
    end

    always_comb begin
        src_fire = active && (cnt == src_q);
        mux_fire = active && (cnt == mux_q);
        last     = active && (cnt == end_q);
    end

    // R10
    kick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        kick |-> !active);
endmodule

// File: rtl/scr_group.sv
module scr_group
    import scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cal_done,
    input  logic [DLY_W-1:0] src_dly,
    input  logic [DLY_W-1:0] mux_dly,
    output logic             cal_start,
    output core_t            cal_core,
    output logic             cal_busy,
    output core_t [1:0]      src_sel,
    output core_t [1:0]      mux_sel,
    output asg_t             asg
);
    rot_st_e st;
    logic    ptr;
    logic    kick, src_fire, mux_fire, last, t_active;

    assign kick = (st == ST_CAL) && cal_done && run;

    scr_swap_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .kick     (kick),
        .src_dly  (src_dly),
        .mux_dly  (mux_dly),
        .src_fire (src_fire),
        .mux_fire (mux_fire),
        .last     (last),
        .active   (t_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            asg       <= '{off: core_t'(2), s1: core_t'(1), s0: core_t'(0)};
            ptr       <= 1'b0;
            src_sel   <= {core_t'(1), core_t'(0)};
            mux_sel   <= {core_t'(1), core_t'(0)};
            cal_start <= 1'b0;
        end else begin
            cal_start <= 1'b0;
            case (st)
                ST_IDLE: if (run) begin
                    st        <= ST_CAL;
                    cal_start <= 1'b1;
                end
                ST_CAL: if (cal_done) st <= run ? ST_SWAP : ST_IDLE;
                ST_SWAP: begin
                    if (src_fire) src_sel[ptr] <= asg.off;
                    if (mux_fire) mux_sel[ptr] <= asg.off;
                    if (last) begin
                        if (ptr == 1'b0) begin
                            asg.s0  <= asg.off;
                            asg.off <= asg.s0;
                        end else begin
                            asg.s1  <= asg.off;
                            asg.off <= asg.s1;
                        end
                        ptr <= ~ptr;
                        if (run) begin
                            st        <= ST_CAL;
                            cal_start <= 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cal_core = asg.off;
    assign cal_busy = (st == ST_CAL);

    // R7
    distinct_chk: assert property (@(posedge clk) disable iff (rst)
        all_distinct(asg));
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> $past(run));
    // R3
    one_cal_chk: assert property (@(posedge clk) disable iff (rst)
        cal_start |-> !$past(cal_busy));
    // R4
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_SWAP) |=> $stable(src_sel));
    // R9
    no_swap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_busy && cal_done && !run) |=> ($stable(asg) && !cal_start));
    // R8
    swap_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SWAP) |-> t_active);
endmodule

// File: rtl/spare_cal_rotator.sv
module spare_cal_rotator
    import scr_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bg_cal_en,
    input  logic                              hw_trig_en,
    input  logic                              sw_trig,
    input  logic [DLY_W-1:0]                  src_dly,
    input  logic [DLY_W-1:0]                  mux_dly,
    input  logic [NUM_GROUPS-1:0]             cal_done,
    output logic [NUM_GROUPS-1:0]             cal_start,
    output logic [NUM_GROUPS*IDX_W-1:0]       cal_core,
    output logic [NUM_GROUPS-1:0]             cal_busy,
    output logic [NUM_GROUPS*SLOTS*IDX_W-1:0] src_sel,
    output logic [NUM_GROUPS*SLOTS*IDX_W-1:0] mux_sel,
    output logic [NUM_GROUPS*SLOTS*IDX_W-1:0] slot_core,
    output logic [NUM_GROUPS*IDX_W-1:0]       spare_core
);
    localparam int GW = SLOTS * IDX_W;

    logic run;
    assign run = bg_cal_en && !hw_trig_en && sw_trig;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        core_t [1:0] s_src, s_mux;
        asg_t        s_asg;
        core_t       s_core;

        scr_group u_grp (
            .clk       (clk),
            .rst       (rst),
            .run       (run),
            .cal_done  (cal_done[g]),
            .src_dly   (src_dly),
            .mux_dly   (mux_dly),
            .cal_start (cal_start[g]),
            .cal_core  (s_core),
            .cal_busy  (cal_busy[g]),
            .src_sel   (s_src),
            .mux_sel   (s_mux),
            .asg       (s_asg)
        );

        assign cal_core[g*IDX_W +: IDX_W] = s_core;
        assign src_sel[g*GW +: GW]        = s_src;
        assign mux_sel[g*GW +: GW]        = s_mux;
        assign slot_core[g*GW +: GW]      = {s_asg.s1, s_asg.s0};
        assign spare_core[g*IDX_W +: IDX_W] = s_asg.off;
    end
endmodule

// File: tb/tb_spare_cal_rotator.sv
module tb_spare_cal_rotator;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bg_cal_en = 1'b0, hw_trig_en = 1'b0, sw_trig = 1'b0;
    logic [4:0] src_dly = 5'd31, mux_dly = 5'd30;
    logic [1:0] cal_done = 2'b00;
    logic [1:0] cal_start, cal_busy;
    logic [3:0] cal_core, spare_core;
    logic [7:0] src_sel, mux_sel, slot_core;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    spare_cal_rotator #(.NUM_GROUPS(2)) dut (
        .clk(clk), .rst(rst), .bg_cal_en(bg_cal_en), .hw_trig_en(hw_trig_en),
        .sw_trig(sw_trig), .src_dly(src_dly), .mux_dly(mux_dly),
        .cal_done(cal_done), .cal_start(cal_start), .cal_core(cal_core),
        .cal_busy(cal_busy), .src_sel(src_sel), .mux_sel(mux_sel),
        .slot_core(slot_core), .spare_core(spare_core)
    );

    function automatic logic [1:0] fld(logic [7:0] v, int g, int s);
        return v[g*4 + s*2 +: 2];
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // group g: returns {slot0, slot1, spare} as 6-bit code
    function automatic int asg_code(int g);
        return {fld(slot_core, g, 0), fld(slot_core, g, 1), spare_core[g*2 +: 2]};
    endfunction

    function automatic int code(int s0, int s1, int off);
        return (s0 << 4) | (s1 << 2) | off;
    endfunction

    task automatic pulse_done(int g);
        cal_done[g] = 1'b1;
        @(negedge clk);
        cal_done[g] = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            chk("R1 slots", asg_code(g), code(0, 1, 2));
            chk("R1 src", {fld(src_sel, g, 0), fld(src_sel, g, 1)}, 4'b0001);
            chk("R1 mux", {fld(mux_sel, g, 0), fld(mux_sel, g, 1)}, 4'b0001);
        end
        chk("R1 busy/start", {cal_busy, cal_start}, 0);
    endtask

    task automatic t_gate();
        int seen;
        logic [2:0] combos [3] = '{3'b001, 3'b111, 3'b100};
        foreach (combos[i]) begin
            {bg_cal_en, hw_trig_en, sw_trig} = combos[i];
            seen = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                seen |= {cal_start, cal_busy};
            end
            chk("R2 no start when gated", seen, 0);
        end
    endtask

    task automatic t_first_swap();
        int g1_code;
        src_dly = 5'd5; mux_dly = 5'd3;
        bg_cal_en = 1'b1; hw_trig_en = 1'b0; sw_trig = 1'b1;
        @(negedge clk);
        chk("R2 start pulse", cal_start, 2'b11);
        chk("R2 cal_core g0", cal_core[1:0], 2);
        chk("R2 cal_core g1", cal_core[3:2], 2);
        @(negedge clk);
        chk("R3 start one cycle", cal_start, 2'b00);
        chk("R3 busy held", cal_busy, 2'b11);
        g1_code = asg_code(1);
        pulse_done(0);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            chk("R4 src slot0", fld(src_sel, 0, 0), (k >= 6) ? 2 : 0);
            chk("R5 mux slot0", fld(mux_sel, 0, 0), (k >= 4) ? 2 : 0);
            chk("R7 commit", asg_code(0), (k >= 6) ? code(2, 1, 0) : code(0, 1, 2));
            chk("R8 restart", cal_start[0], (k == 6) ? 1 : 0);
            chk("R11 g1 busy", cal_busy[1], 1);
            if (k == 6) chk("R8 next core", cal_core[1:0], 0);
        end
        chk("R11 g1 untouched", asg_code(1), g1_code);
    endtask

    task automatic t_rotation();
        int exp [3];
        exp[0] = code(2, 0, 1); exp[1] = code(1, 0, 2); exp[2] = code(1, 2, 0);
        src_dly = 5'd0; mux_dly = 5'd0;
        for (int i = 0; i < 3; i++) begin
            pulse_done(0);
            @(negedge clk);
            chk("R6 order", asg_code(0), exp[i]);
            chk("R6 src follows", {fld(src_sel, 0, 0), fld(src_sel, 0, 1)}, exp[i] >> 2);
            chk("R6 mux follows", {fld(mux_sel, 0, 0), fld(mux_sel, 0, 1)}, exp[i] >> 2);
            chk("R8 cal_core", cal_core[1:0], exp[i] & 3);
        end
    endtask

    task automatic t_latch();
        src_dly = 5'd2; mux_dly = 5'd4;
        cal_done[0] = 1'b1;
        @(negedge clk);
        cal_done[0] = 1'b0;
        src_dly = 5'd31; mux_dly = 5'd31;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R10 src", fld(src_sel, 0, 0), (k >= 3) ? 0 : 1);
            chk("R10 mux", fld(mux_sel, 0, 0), (k >= 5) ? 0 : 1);
            chk("R10 commit", asg_code(0), (k >= 5) ? code(0, 2, 1) : code(1, 2, 0));
            chk("R10 restart", cal_start[0], (k == 5) ? 1 : 0);
        end
    endtask

    task automatic t_disable();
        int seen;
        sw_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 busy kept", cal_busy, 2'b11);
        pulse_done(0);
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            seen |= cal_start;
        end
        chk("R9 no start", seen, 0);
        chk("R9 g0 idle", cal_busy[0], 0);
        chk("R9 g1 still busy", cal_busy[1], 1);
        chk("R9 no swap", asg_code(0), code(0, 2, 1));
        chk("R9 src frozen", {fld(src_sel, 0, 0), fld(src_sel, 0, 1)}, 4'b0010);
        pulse_done(0);
        repeat (3) @(negedge clk);
        chk("R3 stray done", asg_code(0), code(0, 2, 1));
        chk("R3 stray start", {cal_busy[0], cal_start[0]}, 0);
        sw_trig = 1'b1;
        @(negedge clk);
        chk("R2 resume start", cal_start, 2'b01);
        chk("R9 resume core", cal_core[1:0], 1);
    endtask

    task automatic t_group1();
        int g0;
        src_dly = 5'd0; mux_dly = 5'd0;
        @(negedge clk);
        g0 = asg_code(0);
        pulse_done(1);
        @(negedge clk);
        chk("R11 g1 swap", asg_code(1), code(2, 1, 0));
        chk("R11 g1 src", fld(src_sel, 1, 0), 2);
        chk("R11 g0 same", asg_code(0), g0);
        chk("R11 g0 busy", cal_busy[0], 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gate();
        t_first_swap();
        t_rotation();
        t_latch();
        t_disable();
        t_group1();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule